// File: doc/BRIEF.md
# Stream Transfer Address Generator

This block produces the word addresses for one whole-stream transfer between external memory and an on-chip stream buffer. A transfer is described once by a start command carrying a base address, a record count, an addressing mode and a mode parameter. The engine then emits one 32-bit word address per accepted handshake until the stream is exhausted. It never produces single-word requests of its own.

Four addressing modes share one engine. Mode 0 walks the words in order. Mode 1 steps by a programmable stride. Mode 3 visits the words in bit-reversed order, which is the order transform data needs. Mode 2 is indirect: a separate index stream supplies one offset per element, and the same path serves a gather (read) and a scatter (write). The direction bit only travels with the addresses.

The controller is a four-state machine:
- IDLE: waits for start.
- FETCH: indexed mode only. Requests one index word.
- EMIT: presents an address and waits for acceptance.
- DONE: drives the one-cycle completion pulse.

The transitions are:
- IDLE to DONE on a start with zero count.
- IDLE to FETCH on a start in indexed mode.
- IDLE to EMIT on a start in any other mode.
- FETCH to EMIT when an index is accepted.
- EMIT to EMIT (non-indexed) or EMIT to FETCH (indexed) when a non-final address is accepted.
- EMIT to DONE when the final address is accepted.
- DONE to IDLE always.

Top module: `strm_addr_gen`

## Requirements
- R1: After reset, busy, addr_valid, addr_last, idx_ready and done are all low.
- R2: Mode 0 (sequential) emits base + i for i = 0 .. count-1, modulo 2^32.
- R3: Mode 1 (strided) emits base + i * param, modulo 2^32.
- R4: Mode 3 (bit-reversed) takes k = param[4:0] and emits base + the k-bit reversal of i. The caller sets count = 2^k.
- R5: In mode 2 (indexed), idx_ready is raised for each element, and addr_valid stays low while idx_ready is high. Element i is emitted as base + idx_data, only after its index word has been accepted.
- R6: addr_write equals the cmd_write value captured at start, for every address of the transfer (1 = scatter/store, 0 = gather/load).
- R7: addr_last is high with the final address of the transfer and with no other address.
- R8: done is high for exactly one cycle, the cycle after the final address handshake. busy falls in the cycle after done.
- R9: A start that arrives while busy is high is ignored. It does not change the addresses of the running transfer, and it does not produce a transfer of its own.
- R10: A start with count 0 produces done in the next cycle, and no address is emitted.
- R11: While addr_valid is high and addr_ready is low, addr_data, addr_last and addr_valid hold.
- R12: In modes 0, 1 and 3, the first address is valid in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command strobe, taken only when idle |
| cmd_base | input | 32 | Base word address |
| cmd_count | input | 16 | Number of records |
| cmd_mode | input | 2 | 0 sequential, 1 strided, 2 indexed, 3 bit-reversed |
| cmd_param | input | 32 | Stride (mode 1) or log2 size in bits [4:0] (mode 3) |
| cmd_write | input | 1 | 1 = store/scatter, 0 = load/gather |
| busy | output | 1 | High while a transfer or its done cycle is in progress |
| idx_valid | input | 1 | Index word valid |
| idx_data | input | 32 | Index word (element offset) |
| idx_ready | output | 1 | Engine accepts an index word |
| addr_valid | output | 1 | Address valid |
| addr_data | output | 32 | Word address |
| addr_last | output | 1 | Final address of the transfer |
| addr_write | output | 1 | Direction of the transfer |
| addr_ready | input | 1 | Consumer accepts the address |
| done | output | 1 | One-cycle completion pulse |

## Verification
In modes 0, 1 and 3 the first address is due one clock after the edge that takes the start. In mode 2, idx_ready is due one clock after that edge, and each address follows one clock after its index is accepted. done is due one clock after the final address handshake, and busy drops one clock later. A zero-count start gives done one clock after the start. The bench drives inputs and samples outputs only on falling edges. Each check therefore reads the state settled by the preceding rising edge, and a handshake is counted only when the bench saw valid and ready together at the falling edge before that rising edge.

// File: rtl/strm_addr_pkg.sv
package strm_addr_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ    = 2'd0,
        MODE_STRIDE = 2'd1,
        MODE_INDEX  = 2'd2,
        MODE_BITREV = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EMIT  = 2'd2,
        S_DONE  = 2'd3
    } agen_state_e;

endpackage

// File: rtl/strm_elem_counter.sv
module strm_elem_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] count_in,
    input  logic          advance,
    output logic [CW-1:0] elem,
    output logic          is_last
);

    logic [CW-1:0] idx_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            count_q <= '0;
        end else if (load) begin
            idx_q   <= '0;
            count_q <= count_in;
        end else if (advance) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign elem    = idx_q;
    assign is_last = (idx_q == count_q - 1'b1);

    // R7: an element is consumed only while it lies inside the stream
    assert_elem_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (idx_q < count_q));

endmodule

// File: rtl/strm_offset_calc.sv
module strm_offset_calc
    import strm_addr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int KW = 5
) (
    input  amode_e        mode,
    input  logic [CW-1:0] elem,
    input  logic [AW-1:0] param,
    input  logic [AW-1:0] idx_word,
    output logic [AW-1:0] offset
);

    logic [CW-1:0] rev_full;
    logic [CW-1:0] rev_k;
    logic [KW-1:0] k_raw;
    logic [31:0]   k_clamped;
    logic [31:0]   shamt;
    logic [AW-1:0] stride_off;

    // full-width reversal of the element number, one wire per bit
    for (genvar g = 0; g < CW; g++) begin : g_rev
        assign rev_full[g] = elem[CW-1-g];
    end

    assign k_raw     = param[KW-1:0];
    assign k_clamped = (32'(k_raw) > 32'(CW)) ? 32'(CW) : 32'(k_raw);
    assign shamt     = 32'(CW) - k_clamped;
    assign rev_k     = rev_full >> shamt;

    assign stride_off = AW'(elem) * param;

    always_comb begin
        unique case (mode)
            MODE_SEQ:    offset = AW'(elem);
            MODE_STRIDE: offset = stride_off;
            MODE_INDEX:  offset = idx_word;
            MODE_BITREV: offset = AW'(rev_k);
            default:     offset = '0;
        endcase
    end

endmodule

// File: rtl/strm_addr_gen.sv
module strm_addr_gen
    import strm_addr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cmd_base,
    input  logic [CW-1:0] cmd_count,
    input  logic [1:0]    cmd_mode,
    input  logic [AW-1:0] cmd_param,
    input  logic          cmd_write,
    output logic          busy,
    input  logic          idx_valid,
    input  logic [AW-1:0] idx_data,
    output logic          idx_ready,
    output logic          addr_valid,
    output logic [AW-1:0] addr_data,
    output logic          addr_last,
    output logic          addr_write,
    input  logic          addr_ready,
    output logic          done
);

    agen_state_e   state_q, state_d;
    amode_e        mode_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] param_q;
    logic [AW-1:0] idxw_q;
    logic          wr_q;

    logic          take_cmd;
    logic          take_idx;
    logic          take_addr;
    logic [CW-1:0] elem;
    logic          is_last;
    logic [AW-1:0] offset;

    assign take_cmd  = (state_q == S_IDLE) && start;
    assign take_idx  = (state_q == S_FETCH) && idx_valid;
    assign take_addr = (state_q == S_EMIT) && addr_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (cmd_count == '0)                     state_d = S_DONE;
                    else if (amode_e'(cmd_mode) == MODE_INDEX) state_d = S_FETCH;
                    else                                     state_d = S_EMIT;
                end
            end
            S_FETCH: begin
                if (idx_valid) state_d = S_EMIT;
            end
            S_EMIT: begin
                if (addr_ready) begin
                    if (is_last)                  state_d = S_DONE;
                    else if (mode_q == MODE_INDEX) state_d = S_FETCH;
                    else                          state_d = S_EMIT;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        idx_ready  = (state_q == S_FETCH);
        addr_valid = (state_q == S_EMIT);
        addr_last  = (state_q == S_EMIT) && is_last;
        done       = (state_q == S_DONE);
        addr_write = wr_q;
        addr_data  = base_q + offset;
    end

    // command and index capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SEQ;
            base_q  <= '0;
            param_q <= '0;
            wr_q    <= 1'b0;
            idxw_q  <= '0;
        end else begin
            if (take_cmd) begin
                mode_q  <= amode_e'(cmd_mode);
                base_q  <= cmd_base;
                param_q <= cmd_param;
                wr_q    <= cmd_write;
            end
            if (take_idx) idxw_q <= idx_data;
        end
    end

    strm_elem_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cmd),
        .count_in (cmd_count),
        .advance  (take_addr),
        .elem     (elem),
        .is_last  (is_last)
    );

    strm_offset_calc #(.AW(AW), .CW(CW), .KW(KW)) u_off (
        .mode     (mode_q),
        .elem     (elem),
        .param    (param_q),
        .idx_word (idxw_q),
        .offset   (offset)
    );

    assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_data) && $stable(addr_last)));

    assert_index_before_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_valid) && mode_q == MODE_INDEX) |-> $past(idx_valid && idx_ready));

    assert_zero_count_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cmd_count == '0) |=> (done && !addr_valid));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_q));

    assert_first_addr_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cmd_count != '0 && amode_e'(cmd_mode) != MODE_INDEX) |=> addr_valid);

endmodule

// File: tb/strm_addr_gen_test.sv
module strm_addr_gen_test;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int KW = 5;
    localparam int NV = 8;

    typedef struct packed {
        logic [1:0]  mode;
        logic        wr;
        logic        stall;
        logic [15:0] count;
        logic [31:0] param;
        logic [31:0] base;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 1'b0, 1'b0, 16'd5,  32'd0,  32'd100},
        '{2'd1, 1'b1, 1'b0, 16'd4,  32'd16, 32'd1000},
        '{2'd1, 1'b0, 1'b1, 16'd4,  32'd8,  32'hFFFF_FFF0},
        '{2'd3, 1'b0, 1'b0, 16'd8,  32'd3,  32'h200},
        '{2'd2, 1'b1, 1'b0, 16'd5,  32'd0,  32'h4000},
        '{2'd2, 1'b0, 1'b1, 16'd3,  32'd0,  32'h8000},
        '{2'd0, 1'b1, 1'b0, 16'd1,  32'd0,  32'd7},
        '{2'd3, 1'b1, 1'b1, 16'd16, 32'd4,  32'h1000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] cmd_base;
    logic [CW-1:0] cmd_count;
    logic [1:0]    cmd_mode;
    logic [AW-1:0] cmd_param;
    logic          cmd_write;
    logic          busy;
    logic          idx_valid;
    logic [AW-1:0] idx_data;
    logic          idx_ready;
    logic          addr_valid;
    logic [AW-1:0] addr_data;
    logic          addr_last;
    logic          addr_write;
    logic          addr_ready;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    strm_addr_gen #(.AW(AW), .CW(CW), .KW(KW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_base(cmd_base),
        .cmd_count(cmd_count), .cmd_mode(cmd_mode), .cmd_param(cmd_param),
        .cmd_write(cmd_write), .busy(busy), .idx_valid(idx_valid),
        .idx_data(idx_data), .idx_ready(idx_ready), .addr_valid(addr_valid),
        .addr_data(addr_data), .addr_last(addr_last), .addr_write(addr_write),
        .addr_ready(addr_ready), .done(done)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] idx_word(int e);
        return (32'(e) * 32'd37 + 32'd5) ^ 32'h0000_0130;
    endfunction

    function automatic logic [31:0] rev_bits(int e, int k);
        logic [31:0] r = '0;
        logic [31:0] v = 32'(e);
        for (int j = 0; j < k; j++) r[j] = v[k-1-j];
        return r;
    endfunction

    function automatic logic [31:0] exp_addr(vec_t v, int e);
        case (v.mode)
            2'd0:    return v.base + 32'(e);
            2'd1:    return v.base + 32'(e) * v.param;
            2'd2:    return v.base + idx_word(e);
            default: return v.base + rev_bits(e, int'(v.param[4:0]));
        endcase
    endfunction

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic run_vec(vec_t v);
        int e = 0;
        int ic = 0;
        int cyc = 0;
        logic [31:0] held = '0;
        bit stalled = 0;
        @(negedge clk);
        start = 1; cmd_base = v.base; cmd_count = v.count; cmd_mode = v.mode;
        cmd_param = v.param; cmd_write = v.wr;
        idx_valid = (v.mode == 2'd2);
        @(negedge clk);
        start = 0;
        if (v.mode != 2'd2) chk("R12", "first addr valid", addr_valid, 1);
        while (e < int'(v.count) && cyc < 2000) begin
            if (stalled) begin
                chk("R11", "addr held", addr_data, held);
                chk("R11", "valid held", addr_valid, 1);
            end
            stalled = 0;
            if (idx_ready) begin
                chk("R5", "no addr while fetching", addr_valid, 0);
                idx_data = idx_word(ic);
                ic++;
            end
            if (addr_valid) begin
                if (v.stall && (cyc % 3 == 1)) begin
                    addr_ready = 0;
                    held = addr_data;
                    stalled = 1;
                end else begin
                    addr_ready = 1;
                    chk(mode_req(v.mode), "address", addr_data, exp_addr(v, e));
                    chk("R7", "last flag", addr_last, (e == int'(v.count) - 1));
                    chk("R6", "direction", addr_write, v.wr);
                    if (v.mode == 2'd2) chk("R5", "index taken first", ic, e + 1);
                    e++;
                end
            end else begin
                addr_ready = 0;
            end
            cyc++;
            @(negedge clk);
        end
        addr_ready = 0;
        idx_valid = 0;
        chk("R8", "done after last", done, 1);
        chk("R8", "no addr in done", addr_valid, 0);
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        chk("R8", "busy falls", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start = 0; cmd_base = '0; cmd_count = '0; cmd_mode = '0;
        cmd_param = '0; cmd_write = 0; idx_valid = 0; idx_data = '0; addr_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "addr_valid after reset", addr_valid, 0);
        chk("R1", "addr_last after reset", addr_last, 0);
        chk("R1", "idx_ready after reset", idx_ready, 0);
        chk("R1", "done after reset", done, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: zero-count start
        @(negedge clk);
        start = 1; cmd_base = 32'd300; cmd_count = '0; cmd_mode = 2'd0; cmd_write = 0;
        @(negedge clk);
        start = 0;
        chk("R10", "done on zero count", done, 1);
        chk("R10", "no address", addr_valid, 0);
        @(negedge clk);
        chk("R10", "done cleared", done, 0);
        chk("R10", "idle again", busy, 0);
        chk("R10", "still no address", addr_valid, 0);

        // R9: start while busy is ignored
        @(negedge clk);
        start = 1; cmd_base = 32'd50; cmd_count = 16'd3; cmd_mode = 2'd0; cmd_write = 0;
        @(negedge clk);
        chk("R9", "first addr", addr_data, 50);
        cmd_base = 32'd900; cmd_count = '0; cmd_mode = 2'd1; cmd_param = 32'd4;
        @(negedge clk);
        start = 0;
        chk("R9", "busy kept", busy, 1);
        chk("R9", "addr unchanged", addr_data, 50);
        addr_ready = 1;
        for (int e = 0; e < 3; e++) begin
            chk("R9", "running addr", addr_data, 50 + e);
            @(negedge clk);
        end
        addr_ready = 0;
        chk("R9", "done of running stream", done, 1);
        start = 1;
        @(negedge clk);
        start = 0;
        chk("R9", "no second done", done, 0);
        chk("R9", "idle after", busy, 0);
        @(negedge clk);
        chk("R9", "still no done", done, 0);
        chk("R9", "no address from ignored start", addr_valid, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule